// File: doc/BRIEF.md
# Multicycle Accumulator Processor

This block is a small 8-bit processor built around an accumulator. A hardwired control unit runs a step counter. It works with a 64K x 8 external memory through a 16-bit address output, an 8-bit bidirectional data port, a read strobe and a write strobe. The keypad, the display and any other appliance I/O sit in that same address space, and the program reaches them with ordinary load and store instructions.

Every instruction starts with the same three-step fetch. After that, the decoded instruction class and the current time step select the control signals for the remaining steps. Data moves over one shared 16-bit internal bus. There are also direct paths from the data register to the instruction register, from the ALU to the accumulator, and from the memory pins to the data register. A memory operand address follows its opcode as two bytes, low byte first. The low byte waits in a temporary register while the high byte is read.

Top module: `acc_cpu_core`

## Requirements
- R1: With `rst` high, the program counter, address register, accumulator, general register and zero flag all clear to 0. Both strobes are low while `rst` is high. In the first cycle after `rst` falls, the address output is 0 and no strobe is active. In the second cycle the read strobe rises with address 0.
- R2: Each instruction fetches its opcode byte from the address held in the program counter, then increments the counter. Only opcode bits [3:0] select the instruction, and bits [7:4] are ignored. The opcode values are: 0 no-op, 1 load, 2 store, 3 copy accumulator to general register, 4 copy general register to accumulator, 5 jump, 6 jump if zero, 7 jump if not zero, 8 add, 9 subtract, A increment, B clear, C AND, D OR, E XOR, F NOT.
- R3: A load (opcode 1) reads two operand bytes. The first is the low half of a 16-bit address and the second is the high half. The byte at that address goes into the accumulator.
- R4: A store (opcode 2) writes the accumulator to the 16-bit operand address. The write strobe is high for exactly one cycle, in the eighth cycle of the instruction. The data pins are driven only during that cycle.
- R5: Opcode 3 copies the accumulator into the general register. Opcode 4 copies the general register into the accumulator.
- R6: Opcode 8 sets AC to AC+R modulo 256. Opcode 9 sets AC to AC-R modulo 256.
- R7: Opcode A sets AC to AC+1 modulo 256 and opcode B sets AC to 0. Opcode C sets AC to AC AND R, D to AC OR R, E to AC XOR R, and F to the bitwise complement of AC.
- R8: Opcodes 8 to F set the zero flag to 1 when the 8-bit result is zero and to 0 otherwise. All other opcodes leave the zero flag unchanged.
- R9: A jump (opcode 5) loads the program counter with its 16-bit operand, and execution continues at that address.
- R10: Opcode 6 jumps when the zero flag is 1. Opcode 7 jumps when the zero flag is 0. When the jump is not taken, the program counter moves past both operand bytes without reading them.
- R11: No instruction uses more than 8 time steps. Execution continues at the start of the next instruction with no gap. The cycle counts are: single-byte instructions 4, not-taken branches 5, taken branches and jumps 6, loads and stores 8.
- R12: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Memory address, driven from the address register |
| mem_data | inout | 8 | Memory data; the block drives it only during a write |
| mem_rd | output | 1 | Read strobe; data is captured at the end of that cycle |
| mem_wr | output | 1 | Write strobe; memory stores mem_data at the end of that cycle |

## Verification
The bench builds the core with its default 8-bit data width and 4-bit opcode field. These defaults make the modulo-256 wraps of add, subtract and increment reachable with single operand bytes, along with the zero flag that each wrap produces. The full 16-bit address path comes within reach through operands with a nonzero high byte, which land in a 512-byte memory model next to a decoy at the same low byte. Cycle counts are checked by timing the first write strobe of a program whose instruction sequence is fixed.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'h0, OP_LDAC = 4'h1, OP_STAC = 4'h2, OP_MVAC = 4'h3,
    OP_MOVR = 4'h4, OP_JUMP = 4'h5, OP_JMPZ = 4'h6, OP_JPNZ = 4'h7,
    OP_ADD  = 4'h8, OP_SUB  = 4'h9, OP_INAC = 4'hA, OP_CLAC = 4'hB,
    OP_AND  = 4'hC, OP_OR   = 4'hD, OP_XOR  = 4'hE, OP_NOT  = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_INC, ALU_CLR, ALU_AND, ALU_OR, ALU_XOR, ALU_NOT
  } alu_op_e;

  typedef enum logic [2:0] {
    BUS_NONE, BUS_PC, BUS_DR, BUS_TR, BUS_AC, BUS_R, BUS_ADDR
  } bus_src_e;

  typedef struct packed {
    bus_src_e bus;
    logic     ld_ar;
    logic     inc_ar;
    logic     ld_pc;
    logic     inc_pc;
    logic     ld_dr_mem;
    logic     ld_dr_bus;
    logic     ld_ir;
    logic     ld_tr;
    logic     ld_ac_bus;
    logic     ld_r;
    logic     alu_en;
    alu_op_e  alu_op;
    logic     mem_rd;
    logic     mem_wr;
    logic     done;
  } ctrl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);

  logic [W-1:0] opb, g, p, c, sum;
  logic         cin;
  logic         run;

  // Single-level lookahead: each carry is a flat OR of generate/propagate products.
  always_comb begin
    opb = b;
    cin = 1'b0;
    case (op)
      ALU_SUB: begin opb = ~b; cin = 1'b1; end
      ALU_INC: begin opb = '0; cin = 1'b1; end
      default: opb = b;
    endcase
    g = a & opb;
    p = a ^ opb;
    c = '0;
    run = 1'b0;
    for (int i = 0; i < W; i++) begin
      run = cin;
      for (int k = 0; k < i; k++) run = run & p[k];
      c[i] = run;
      for (int j = 0; j < i; j++) begin
        run = g[j];
        for (int k = j + 1; k < i; k++) run = run & p[k];
        c[i] = c[i] | run;
      end
    end
    sum = p ^ c;
    case (op)
      ALU_ADD, ALU_SUB, ALU_INC: y = sum;
      ALU_CLR: y = '0;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      default: y = ~a;
    endcase
  end

endmodule

// File: rtl/acc_decode.sv
module acc_decode #(
  parameter int OPC_W = 4,
  localparam int NUM_OPS = 1 << OPC_W
) (
  input  logic [OPC_W-1:0]   opc,
  output logic [NUM_OPS-1:0] lines
);

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_line
    assign lines[i] = (opc == OPC_W'(i));
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int MAX_STEPS = 8,
  parameter int NUM_OPS   = 16,
  localparam int STEP_W   = $clog2(MAX_STEPS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OPS-1:0] lines,
  input  logic               zf,
  output ctrl_t              ctl,
  output logic [STEP_W-1:0]  step
);

  logic take, addr_ins, skip, one_byte, is_alu;

  always_ff @(posedge clk) begin
    if (rst)           step <= '0;
    else if (ctl.done) step <= '0;
    else               step <= step + 1'b1;
  end

  always_comb begin
    take     = lines[OP_JUMP] | (lines[OP_JMPZ] & zf) | (lines[OP_JPNZ] & ~zf);
    addr_ins = lines[OP_LDAC] | lines[OP_STAC] | take;
    skip     = (lines[OP_JMPZ] | lines[OP_JPNZ]) & ~take;
    is_alu   = |lines[OP_NOT:OP_ADD];
    one_byte = lines[OP_NOP] | lines[OP_MVAC] | lines[OP_MOVR] | is_alu;
    ctl = '0;
    case (step)
      STEP_W'(0): begin ctl.bus = BUS_PC; ctl.ld_ar = 1'b1; end
      STEP_W'(1): begin ctl.mem_rd = 1'b1; ctl.ld_dr_mem = 1'b1; ctl.inc_pc = 1'b1; end
      STEP_W'(2): begin ctl.ld_ir = 1'b1; ctl.bus = BUS_PC; ctl.ld_ar = 1'b1; end
      default: begin
        if (addr_ins) begin
          case (step)
            STEP_W'(3): begin
              ctl.mem_rd = 1'b1; ctl.ld_dr_mem = 1'b1; ctl.inc_pc = 1'b1; ctl.inc_ar = 1'b1;
            end
            STEP_W'(4): begin
              ctl.bus = BUS_DR; ctl.ld_tr = 1'b1;
              ctl.mem_rd = 1'b1; ctl.ld_dr_mem = 1'b1; ctl.inc_pc = 1'b1;
            end
            STEP_W'(5): begin
              ctl.bus = BUS_ADDR;
              if (take) begin ctl.ld_pc = 1'b1; ctl.done = 1'b1; end
              else      ctl.ld_ar = 1'b1;
            end
            STEP_W'(6): begin
              if (lines[OP_LDAC]) begin ctl.mem_rd = 1'b1; ctl.ld_dr_mem = 1'b1; end
              else begin ctl.bus = BUS_AC; ctl.ld_dr_bus = 1'b1; end
            end
            default: begin
              ctl.done = 1'b1;
              if (lines[OP_LDAC]) begin ctl.bus = BUS_DR; ctl.ld_ac_bus = 1'b1; end
              else                ctl.mem_wr = 1'b1;
            end
          endcase
        end else if (skip) begin
          ctl.inc_pc = 1'b1;
          ctl.done   = (step != STEP_W'(3));
        end else begin
          ctl.done = one_byte;
          if (lines[OP_MVAC]) begin ctl.bus = BUS_AC; ctl.ld_r = 1'b1; end
          if (lines[OP_MOVR]) begin ctl.bus = BUS_R; ctl.ld_ac_bus = 1'b1; end
          ctl.alu_en = is_alu;
          if      (lines[OP_SUB])  ctl.alu_op = ALU_SUB;
          else if (lines[OP_INAC]) ctl.alu_op = ALU_INC;
          else if (lines[OP_CLAC]) ctl.alu_op = ALU_CLR;
          else if (lines[OP_AND])  ctl.alu_op = ALU_AND;
          else if (lines[OP_OR])   ctl.alu_op = ALU_OR;
          else if (lines[OP_XOR])  ctl.alu_op = ALU_XOR;
          else if (lines[OP_NOT])  ctl.alu_op = ALU_NOT;
          else                     ctl.alu_op = ALU_ADD;
        end
      end
    endcase
  end

  // R11: the last time step always ends the instruction
  assert_step_limit_R11: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_W'(MAX_STEPS - 1)) |-> ctl.done);

  // R11: a finished instruction is followed by T0
  assert_step_restart_R11: assert property (@(posedge clk) disable iff (rst)
    ctl.done |=> (step == '0));

  // R4: a write happens only in the closing step of an instruction
  assert_wr_closing_R4: assert property (@(posedge clk) disable iff (rst)
    ctl.mem_wr |-> ctl.done);

  // R12: strobes are mutually exclusive
  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(ctl.mem_rd && ctl.mem_wr));

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OPC_W     = 4,
  parameter int MAX_STEPS = 8,
  localparam int ADDR_W   = 2 * DATA_W,
  localparam int NUM_OPS  = 1 << OPC_W,
  localparam int STEP_W   = $clog2(MAX_STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_data,
  output logic              mem_rd,
  output logic              mem_wr
);

  ctrl_t               ctl;
  logic [STEP_W-1:0]   step;
  logic [NUM_OPS-1:0]  lines;
  logic [ADDR_W-1:0]   pc_q, ar_q, bus;
  logic [DATA_W-1:0]   dr_q, tr_q, ac_q, r_q, alu_y;
  logic [OPC_W-1:0]    ir_q;
  logic                z_q;

  acc_decode #(.OPC_W(OPC_W)) u_decode (.opc(ir_q), .lines(lines));

  acc_ctrl #(.MAX_STEPS(MAX_STEPS), .NUM_OPS(NUM_OPS)) u_ctrl (
    .clk(clk), .rst(rst), .lines(lines), .zf(z_q), .ctl(ctl), .step(step)
  );

  acc_alu #(.W(DATA_W)) u_alu (.a(ac_q), .b(r_q), .op(ctl.alu_op), .y(alu_y));

  always_comb begin
    case (ctl.bus)
      BUS_PC:   bus = pc_q;
      BUS_DR:   bus = ADDR_W'(dr_q);
      BUS_TR:   bus = ADDR_W'(tr_q);
      BUS_AC:   bus = ADDR_W'(ac_q);
      BUS_R:    bus = ADDR_W'(r_q);
      BUS_ADDR: bus = {dr_q, tr_q};
      default:  bus = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0; ar_q <= '0; dr_q <= '0; tr_q <= '0;
      ir_q <= '0; ac_q <= '0; r_q  <= '0; z_q  <= 1'b0;
    end else begin
      if (ctl.ld_pc)          pc_q <= bus;
      else if (ctl.inc_pc)    pc_q <= pc_q + 1'b1;
      if (ctl.ld_ar)          ar_q <= bus;
      else if (ctl.inc_ar)    ar_q <= ar_q + 1'b1;
      if (ctl.ld_dr_mem)      dr_q <= mem_data;
      else if (ctl.ld_dr_bus) dr_q <= bus[DATA_W-1:0];
      if (ctl.ld_ir)          ir_q <= dr_q[OPC_W-1:0];
      if (ctl.ld_tr)          tr_q <= bus[DATA_W-1:0];
      if (ctl.alu_en)         ac_q <= alu_y;
      else if (ctl.ld_ac_bus) ac_q <= bus[DATA_W-1:0];
      if (ctl.ld_r)           r_q  <= bus[DATA_W-1:0];
      if (ctl.alu_en)         z_q  <= (alu_y == '0);
    end
  end

  assign mem_addr = ar_q;
  assign mem_rd   = ctl.mem_rd;
  assign mem_wr   = ctl.mem_wr;
  assign mem_data = ctl.mem_wr ? dr_q : 'z;

  // R8: the flag reflects the result an ALU step just wrote
  assert_zero_value_R8: assert property (@(posedge clk) disable iff (rst)
    ctl.alu_en |=> (z_q == (ac_q == '0)));

  // R8: non-ALU steps hold the flag
  assert_zero_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ctl.alu_en |=> $stable(z_q));

  // R6: the lookahead adder agrees with plain modulo addition
  assert_cla_add_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl.alu_en && ctl.alu_op == ALU_ADD) |-> (alu_y == DATA_W'(ac_q + r_q)));

  // R2: the opcode fetch step advances the program counter by one
  assert_fetch_inc_R2: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_W'(1)) |=> (pc_q == $past(pc_q) + 1'b1));

endmodule

// File: tb/acc_cpu_core_test.sv
`timescale 1ns/1ps
module acc_cpu_core_test;

  typedef struct packed {
    logic [7:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] res;
    logic       zf;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{8'h08, 8'h35, 8'h4A, 8'h7F, 1'b0},
    '{8'h08, 8'hFF, 8'h01, 8'h00, 1'b1},
    '{8'h09, 8'h10, 8'h10, 8'h00, 1'b1},
    '{8'h09, 8'h05, 8'h07, 8'hFE, 1'b0},
    '{8'h0A, 8'hFF, 8'h00, 8'h00, 1'b1},
    '{8'h0A, 8'h41, 8'h00, 8'h42, 1'b0},
    '{8'h0B, 8'h99, 8'h12, 8'h00, 1'b1},
    '{8'h0C, 8'hF0, 8'h3C, 8'h30, 1'b0},
    '{8'h0D, 8'hA0, 8'h05, 8'hA5, 1'b0},
    '{8'h0E, 8'h5A, 8'h5A, 8'h00, 1'b1},
    '{8'h0F, 8'h0F, 8'h00, 8'hF0, 1'b0},
    '{8'h00, 8'h77, 8'h01, 8'h77, 1'b0},
    '{8'h04, 8'h11, 8'h22, 8'h22, 1'b0},
    '{8'h03, 8'h33, 8'h44, 8'h33, 1'b0},
    '{8'h18, 8'h01, 8'h02, 8'h03, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  wire  [7:0]  mem_data;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem [0:511];
  int          checks = 0, failures = 0;
  int          cyc = 0, first_wr = -1;
  logic        bad_rd = 1'b0, both = 1'b0, finished = 1'b0;

  always #5 clk = ~clk;

  acc_cpu_core uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  assign mem_data = mem_rd ? mem[mem_addr[8:0]] : 8'bz;

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[8:0]] <= mem_data;
    if (rst) cyc <= 0; else cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd && (mem_addr == 16'd2 || mem_addr == 16'd3)) bad_rd = 1'b1;
      if (mem_rd && mem_wr) both = 1'b1;
      if (mem_wr && first_wr < 0) first_wr = cyc;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = 8'hEE;
  endtask

  task automatic restart();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    first_wr = -1;
    bad_rd = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic string req_of(input logic [3:0] op);
    if (op == 4'h8 || op == 4'h9) return "R6";
    if (op >= 4'hA) return "R7";
    if (op == 4'h3 || op == 4'h4) return "R5";
    return "R2";
  endfunction

  initial begin
    // R1: reset state and first fetch
    clear_mem();
    mem[0] = 8'h00;
    restart();
    chk("R1 rd low after reset", int'(mem_rd), 0);
    chk("R1 addr zero after reset", int'(mem_addr), 0);
    @(negedge clk);
    chk("R1 first fetch reads", int'(mem_rd), 1);
    chk("R1 first fetch address", int'(mem_addr), 0);

    // Vector table: R6 R7 R5 R2 R8 R4 R3
    for (int v = 0; v < NVEC; v++) begin
      clear_mem();
      mem[8'h80] = VECS[v].b;
      mem[8'h81] = VECS[v].a;
      mem[0]  = 8'h01; mem[1]  = 8'h80; mem[2]  = 8'h00;
      mem[3]  = 8'h03;
      mem[4]  = 8'h01; mem[5]  = 8'h81; mem[6]  = 8'h00;
      mem[7]  = VECS[v].op;
      mem[8]  = 8'h02; mem[9]  = 8'h90; mem[10] = 8'h00;
      mem[11] = 8'h06; mem[12] = 8'h40; mem[13] = 8'h00;
      mem[14] = 8'h05; mem[15] = 8'h0E; mem[16] = 8'h00;
      mem[8'h40] = 8'h02; mem[8'h41] = 8'h91; mem[8'h42] = 8'h00;
      mem[8'h43] = 8'h05; mem[8'h44] = 8'h43; mem[8'h45] = 8'h00;
      restart();
      repeat (100) @(negedge clk);
      chk($sformatf("%s result op=%0h", req_of(VECS[v].op[3:0]), VECS[v].op),
          int'(mem[8'h90]), int'(VECS[v].res));
      chk($sformatf("R8 zero flag op=%0h", VECS[v].op),
          int'(mem[8'h91] != 8'hEE), int'(VECS[v].zf));
    end

    // R9 jump, R3 high address byte, R4 store address
    clear_mem();
    mem[0] = 8'h05; mem[1] = 8'h30; mem[2] = 8'h00;
    mem[3] = 8'h02; mem[4] = 8'h95; mem[5] = 8'h00;
    mem[8'h30] = 8'h01; mem[8'h31] = 8'h10; mem[8'h32] = 8'h01;
    mem[8'h33] = 8'h02; mem[8'h34] = 8'h20; mem[8'h35] = 8'h01;
    mem[8'h36] = 8'h05; mem[8'h37] = 8'h36; mem[8'h38] = 8'h00;
    mem[9'h110] = 8'h6C; mem[9'h010] = 8'h11;
    restart();
    repeat (60) @(negedge clk);
    chk("R9 skipped store untouched", int'(mem[8'h95]), 8'hEE);
    chk("R3 load from high page", int'(mem[9'h120]), 8'h6C);
    chk("R4 low-page alias untouched", int'(mem[9'h020]), 8'hEE);

    // R10 both branch outcomes, R11 cycle count
    clear_mem();
    mem[0] = 8'h0B;
    mem[1] = 8'h07; mem[2] = 8'h50; mem[3] = 8'h00;
    mem[4] = 8'h0A;
    mem[5] = 8'h07; mem[6] = 8'h20; mem[7] = 8'h00;
    mem[8] = 8'h02; mem[9] = 8'h92; mem[10] = 8'h00;
    mem[8'h20] = 8'h02; mem[8'h21] = 8'h93; mem[8'h22] = 8'h00;
    mem[8'h23] = 8'h05; mem[8'h24] = 8'h23; mem[8'h25] = 8'h00;
    restart();
    repeat (60) @(negedge clk);
    chk("R10 taken branch store", int'(mem[8'h93]), 8'h01);
    chk("R10 fall-through skipped", int'(mem[8'h92]), 8'hEE);
    chk("R10 operand bytes not read", int'(bad_rd), 0);
    chk("R11 write cycle 4+5+4+6+7", first_wr, 26);
    chk("R12 strobes exclusive", int'(both), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule